// File: doc/BRIEF.md
# Slave Grant Controller with Idle Parking

This block decides which bus master owns one slave port of a multi-master interconnect. Each master raises a request line, and the block answers with a one-hot grant vector that connects the slave to a single master or to none. A master that holds the grant keeps it until it pulses `done_i`. If several masters compete for the slave, the next owner is chosen round-robin, and the search begins just after the master that last made an access.

When an access ends and no other master is waiting, the slave is parked. The park mode chooses what happens: the slave is disconnected, it stays with the master that just finished, or it sits on a configured master. A parked master that raises its request starts its access on the next clock edge, because its grant is already showing. Any other master first receives the grant at one edge and starts its access at the following edge, so it pays one cycle.

A request works like a valid signal and the grant works like ready. The rule for back-pressure is that a master holds its request high until the grant shows it and the access starts (`busy_o` rises with the grant on that master). It may then drop the request. It raises `done_i` for exactly one cycle, and only while its access is active.

Top module: `slave_park_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zeros, `busy_o` is 0, and the last-access record is master 0.
- R2: `grant_o` never has more than one bit set.
- R3: While `busy_o` is 1, `grant_o` does not change until `done_i` is 1. A `done_i` pulse while `busy_o` is 0 has no effect.
- R4: If the slave is idle and the master whose grant bit is already set requests, `busy_o` is 1 after the next edge and `grant_o` is unchanged (zero added latency).
- R5: If the slave is idle and only masters without the grant request, the next edge moves the grant to the chosen master with `busy_o` still 0. The access starts one edge later.
- R6: Among simultaneous requesters, the winner is the first one found by searching upward from the index after the last-access master, wrapping past the top.
- R7: When `done_i` ends an access and other masters are requesting, the grant moves to the round-robin winner among them, and no parking happens.
- R8: Park mode `cfg_mode_i` = 00 (none) or 11 (reserved, treated as none): an access that ends with no other request pending clears `grant_o` to zero.
- R9: Park mode 01 (last): an access that ends with no other request pending leaves the grant on the master that just finished.
- R10: Park mode 10 (fixed): an access that ends with no other request pending moves the grant to master `cfg_fixed_i`. In the other modes `cfg_fixed_i` is ignored.
- R11: The park configuration is sampled only on the edge where an access ends. Changing it while the slave is parked or busy leaves `grant_o` as it is.
- R12: After reset, a first round of simultaneous requests from masters 0 and 1 grants master 1, since the search starts after master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | One request line per master |
| done_i | input | 1 | One-cycle pulse from the owning master that ends its access |
| cfg_mode_i | input | 2 | Park mode: 00 none, 01 last, 10 fixed, 11 none |
| cfg_fixed_i | input | 4 | Master to park on in fixed mode |
| grant_o | output | NUM_MASTERS | One-hot or zero grant vector |
| busy_o | output | 1 | An access is in progress for the granted master |

## Verification
The embedded properties check on every cycle that the grant is one-hot or zero and that it holds through an active access. They also check that a request from the parked master starts its access at once, that a request from any other master does not start an access on that edge, and that an access ending in none mode with nobody waiting clears the grant. The bench's scenarios and its reference model are needed to show the round-robin order after reset and after a parked master. They also show the exact park target in last and fixed mode, that `cfg_fixed_i` is ignored outside fixed mode, and that configuration changes while parked have no effect.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_FIXED = 2'b10,
    PARK_RSVD  = 2'b11
  } park_mode_e;

  localparam int FIXED_IDX_W = 4;

endpackage

// File: rtl/spa_rr_pick.sv
module spa_rr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] after_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  // Search upward starting one past after_i, wrapping at N.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      int pos;
      pos = (int'(after_i) + k) % N;
      if (!found_o && cand_i[pos]) begin
        found_o = 1'b1;
        idx_o   = IW'(pos);
      end
    end
  end

endmodule

// File: rtl/spa_park_sel.sv
module spa_park_sel
  import spa_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  park_mode_e             mode_i,
  input  logic [FIXED_IDX_W-1:0] fixed_i,
  input  logic [IW-1:0]          last_i,
  output logic                   park_vld_o,
  output logic [IW-1:0]          park_idx_o
);

  always_comb begin
    park_vld_o = 1'b0;
    park_idx_o = '0;
    unique case (mode_i)
      PARK_LAST: begin
        park_vld_o = 1'b1;
        park_idx_o = last_i;
      end
      PARK_FIXED: begin
        // an index beyond the master count parks nowhere
        if (int'(fixed_i) < N) begin
          park_vld_o = 1'b1;
          park_idx_o = IW'(fixed_i);
        end
      end
      default: begin
        park_vld_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/slave_park_arbiter.sv
module slave_park_arbiter
  import spa_pkg::*;
#(
  parameter int NUM_MASTERS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   done_i,
  input  logic [1:0]             cfg_mode_i,
  input  logic [3:0]             cfg_fixed_i,
  output logic [NUM_MASTERS-1:0] grant_o,
  output logic                   busy_o
);

  localparam int N  = NUM_MASTERS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  grant_q, grant_d;
  logic          busy_q, busy_d;
  logic [IW-1:0] last_q, last_d;
  logic [IW-1:0] owner_idx;
  logic [N-1:0]  pend;
  logic          park_hit;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic          park_vld;
  logic [IW-1:0] park_idx;
  logic [N-1:0]  pick_oh, park_oh;

  // index of the master whose grant bit is set
  always_comb begin
    owner_idx = '0;
    for (int m = 0; m < N; m++) begin
      if (grant_q[m]) owner_idx = IW'(m);
    end
  end

  // while busy the owner is excluded: only other requests count as pending
  assign pend     = busy_q ? (req_i & ~grant_q) : req_i;
  assign park_hit = |(req_i & grant_q);

  spa_rr_pick #(.N(N), .IW(IW)) rr_i (
    .cand_i  (pend),
    .after_i (last_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  spa_park_sel #(.N(N), .IW(IW)) park_i (
    .mode_i     (park_mode_e'(cfg_mode_i)),
    .fixed_i    (cfg_fixed_i),
    .last_i     (last_q),
    .park_vld_o (park_vld),
    .park_idx_o (park_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_oh
    assign pick_oh[g] = (pick_idx == IW'(g));
    assign park_oh[g] = park_vld && (park_idx == IW'(g));
  end

  always_comb begin
    grant_d = grant_q;
    busy_d  = busy_q;
    last_d  = last_q;
    if (busy_q) begin
      if (done_i) begin
        busy_d = 1'b0;
        if (pick_found) grant_d = pick_oh;
        else            grant_d = park_oh;
      end
    end else if (park_hit) begin
      busy_d = 1'b1;
      last_d = owner_idx;
    end else if (pick_found) begin
      grant_d = pick_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
      last_q  <= '0;
    end else begin
      grant_q <= grant_d;
      busy_q  <= busy_d;
      last_q  <= last_d;
    end
  end

  assign grant_o = grant_q;
  assign busy_o  = busy_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_i |=> busy_o && $stable(grant_o));

  // R4
  park_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && |(req_i & grant_o) |=> busy_o && $stable(grant_o));

  // R5
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !(|(req_i & grant_o)) |=> !busy_o);

  // R8
  none_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && done_i && ((req_i & ~grant_o) == '0) &&
    (cfg_mode_i == 2'b00 || cfg_mode_i == 2'b11) |=> grant_o == '0);

  // R6
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> pend[pick_idx]);

endmodule

// File: tb/slave_park_arbiter_tb_top.sv
module slave_park_arbiter_tb_top;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [3:0]   fix = 4'd0;
  logic [N-1:0] grant;
  logic         busy;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [N-1:0] m_grant;
  logic         m_busy;
  int           m_last;

  always #10 clk = ~clk;

  slave_park_arbiter #(.NUM_MASTERS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .cfg_mode_i(mode), .cfg_fixed_i(fix), .grant_o(grant), .busy_o(busy)
  );

  function automatic logic [N-1:0] oh(input int i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic int first_after(input logic [N-1:0] c, input int p);
    for (int k = 1; k <= N; k++) begin
      if (c[(p + k) % N]) return (p + k) % N;
    end
    return -1;
  endfunction

  function automatic int idx_of(input logic [N-1:0] v);
    for (int m = 0; m < N; m++) if (v[m]) return m;
    return 0;
  endfunction

  task automatic model_step();
    logic [N-1:0] p;
    if (m_busy) begin
      if (done) begin
        m_busy = 1'b0;
        p = req & ~m_grant;
        if (p != '0) m_grant = oh(first_after(p, m_last));
        else if (mode == 2'b01) m_grant = oh(m_last);
        else if (mode == 2'b10) m_grant = oh(int'(fix));
        else m_grant = '0;
      end
    end else if ((req & m_grant) != '0) begin
      m_busy = 1'b1;
      m_last = idx_of(m_grant);
    end else if (req != '0) begin
      m_grant = oh(first_after(req, m_last));
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle from just after a negedge, compare at the next negedge
  task automatic cyc(input logic [N-1:0] r, input logic d, input logic [1:0] md,
                     input logic [3:0] fx);
    req = r; done = d; mode = md; fix = fx;
    model_step();
    @(negedge clk);
    check(grant == m_grant, "R2 grant vs model", grant, m_grant);
    check(busy == m_busy, "R3 busy vs model", {{(N-1){1'b0}}, busy},
          {{(N-1){1'b0}}, m_busy});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
  end

  initial begin
    logic [N-1:0] want;
    bit prev_busy;
    void'($urandom(32'd20240611));
    m_grant = '0; m_busy = 1'b0; m_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(grant == '0 && busy == 1'b0, "R1 reset", grant, '0);

    // R12 first round after reset: masters 0 and 1, search starts after 0
    cyc(16'h0003, 0, 2'b01, 4'd0);
    check(grant == 16'h0002 && !busy, "R12 first winner", grant, 16'h0002);
    cyc(16'h0003, 0, 2'b01, 4'd0);
    check(busy == 1'b1, "R5 start one edge later", {15'd0, busy}, 16'h0001);
    cyc(16'h0001, 0, 2'b01, 4'd0);
    check(grant == 16'h0002 && busy, "R3 grant held", grant, 16'h0002);
    cyc(16'h0001, 1, 2'b01, 4'd0);
    check(grant == 16'h0001 && !busy, "R7 handover on done", grant, 16'h0001);
    cyc(16'h0001, 0, 2'b01, 4'd0);
    cyc(16'h0000, 1, 2'b01, 4'd0);
    check(grant == 16'h0001 && !busy, "R9 park on last", grant, 16'h0001);
    cyc(16'h0000, 0, 2'b00, 4'd9);
    cyc(16'h0000, 0, 2'b10, 4'd3);
    check(grant == 16'h0001, "R11 config ignored while parked", grant, 16'h0001);
    cyc(16'h0001, 0, 2'b01, 4'd0);
    check(grant == 16'h0001 && busy, "R4 zero latency", grant, 16'h0001);
    cyc(16'h0000, 1, 2'b10, 4'd5);
    check(grant == 16'h0020 && !busy, "R10 park on fixed", grant, 16'h0020);
    cyc(16'h0008, 0, 2'b10, 4'd5);
    check(grant == 16'h0008 && !busy, "R5 non-parked waits", grant, 16'h0008);
    cyc(16'h0008, 0, 2'b10, 4'd5);
    cyc(16'h0000, 1, 2'b11, 4'd5);
    check(grant == '0, "R8 reserved mode disconnects", grant, '0);
    cyc(16'h0000, 1, 2'b01, 4'd0);
    check(grant == '0 && !busy, "R3 stray done ignored", grant, '0);
    cyc(16'h0080, 0, 2'b01, 4'd0);
    cyc(16'h0080, 0, 2'b01, 4'd0);
    cyc(16'h0000, 1, 2'b01, 4'd2);
    check(grant == 16'h0080, "R10 index ignored in last mode", grant, 16'h0080);
    cyc(16'h0204, 0, 2'b01, 4'd2);
    check(grant == 16'h0200, "R6 search after last master", grant, 16'h0200);
    cyc(16'h0204, 0, 2'b01, 4'd2);
    cyc(16'h0004, 1, 2'b01, 4'd2);
    check(grant == 16'h0004, "R7 waiting master wins", grant, 16'h0004);
    cyc(16'h0004, 0, 2'b00, 4'd0);
    cyc(16'h0000, 1, 2'b00, 4'd0);
    check(grant == '0, "R8 none mode disconnects", grant, '0);

    // constrained random traffic against the model
    want = '0;
    for (int t = 0; t < 4000; t++) begin
      logic [1:0] md;
      logic [3:0] fx;
      logic d;
      md = mode; fx = fix;
      for (int m = 0; m < N; m++) begin
        if (!want[m] && ($urandom % 10 == 0)) want[m] = 1'b1;
      end
      if ($urandom % 12 == 0) md = 2'($urandom);
      if ($urandom % 12 == 0) fx = 4'($urandom);
      d = m_busy && ($urandom % 3 == 0);
      prev_busy = m_busy;
      cyc(want, d, md, fx);
      if (m_busy && !prev_busy) want[m_last] = 1'b0;
    end
    summary();
  end

endmodule